// File: doc/BRIEF.md
# Timer Control Register Access Trap Router

This block decides what happens when software executes a system-register read or write that names the physical timer control register. It looks at the instruction's encoding fields, the exception level the request comes from and a set of hypervisor, kernel and security control bits. It then resolves the access to exactly one outcome:

- a trap to level 1,
- a trap to level 2,
- an undefined-instruction exception, or
- a redirect of the access to a storage target.

The storage target is one of four places: the plain timer control register, the hypervisor physical timer control register, the secure hypervisor timer control register, or a memory slot at offset 0x180.

The rules are evaluated in a fixed priority order. The first condition that holds wins. Traps always report syndrome class 0x18. The decision is computed combinationally from the request and registered once, so each result appears on the response ports in the cycle after the request. The register storage itself and the exception entry sequence belong to neighbouring blocks; this block only routes.

Top module: `timer_ctl_access_router`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one cycle after a request, and only if the request's encoding matches one of two forms. The direct form is op0=0b11, op1=0b011, CRn=0b1110, CRm=0b0010, op2=0b001. The alias form is the same except op1=0b101. A request with any other encoding, or no request, gives `rsp_valid`=0 in the next cycle.
- R2: With `rsp_valid`=1, exactly one of `rsp_trap_l1`, `rsp_trap_l2`, `rsp_undef`, `rsp_redirect` is 1. With `rsp_valid`=0 all four are 0, which is also the state after reset.
- R3: `rsp_syndrome` is 0x18 when either trap output is 1 and 0 otherwise. `rsp_target` is 0 unless `rsp_redirect` is 1, and uses these codes: 0 plain register, 1 hypervisor timer, 2 secure hypervisor timer, 3 memory slot. `rsp_slot_offset` is 0x180 when the target is 3 and 0 otherwise.
- R4: Direct form at level 0, with `host_l0`=0 and `kctl_l0_timer_en`=0: the access traps to level 2 when `l2_enabled`=1 and `trap_general`=1, and traps to level 1 otherwise. This check has the highest priority at level 0.
- R5: Direct form at level 0, below R4, the following checks apply in this order, and each one that holds traps to level 2:
  - `l2_enabled`=1, `host_l2`=0 and `hctl_l1_cnt_en`=0;
  - `host_l2`=1, `trap_general`=0 and `hctl_l1_timer_en`=0;
  - `host_l0`=1 and `hctl_l0_timer_en`=0.
- R6: Redirect choice, applied after the R4/R5 checks at level 0 (using `host_l0`) and directly at level 2 (using `host_l2`). When the host flag is 1:
  - `nonsecure`=0 with `sec_l2_impl`=1 gives target 2;
  - `nonsecure`=1 gives target 1;
  - any other case gives target 0.
- R7: Direct form at level 1: traps to level 2 if `l2_enabled`=1, `host_l2`=0 and `hctl_l1_cnt_en`=0, or if `host_l2`=1 and `hctl_l1_timer_en`=0. Otherwise `nv_bits`=0b111 gives target 3, and any other value gives target 0.
- R8: Direct form at level 3 always redirects to target 0, whatever the control bits.
- R9: Alias form at level 0 is undefined. At levels 2 and 3, the alias form redirects to target 0 when `host_l2`=1 and is undefined otherwise.
- R10: Alias form at level 1 depends on `nv_bits`:
  - 0b101: traps to level 2 when `l2_enabled`=1, `host_l0`=0 and `hctl_l1_nv_trap`=1; otherwise redirects to target 3.
  - any other value with bit 0 set: traps to level 2.
  - all remaining values: undefined.
- R11: Reads (`req_write`=0) and writes (`req_write`=1) are routed identically, and `rsp_write` returns the request's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Current exception level 0..3 |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| l2_enabled | input | 1 | Level 2 is enabled |
| host_l2 | input | 1 | Level 2 runs in host mode |
| host_l0 | input | 1 | Level 0 runs under a host-mode level 2 |
| trap_general | input | 1 | Hypervisor general-trap bit |
| nv_bits | input | 3 | Effective nested-virtualisation bits |
| nonsecure | input | 1 | Non-secure state bit |
| sec_l2_impl | input | 1 | Secure level 2 is implemented |
| kctl_l0_timer_en | input | 1 | Kernel control: level-0 physical timer access allowed |
| hctl_l1_cnt_en | input | 1 | Hypervisor control: level-1 physical counter access allowed |
| hctl_l1_timer_en | input | 1 | Hypervisor control: level-1 physical timer access allowed (host mode) |
| hctl_l0_timer_en | input | 1 | Hypervisor control: level-0 physical timer access allowed (host mode) |
| hctl_l1_nv_trap | input | 1 | Hypervisor control: trap nested alias physical timer access |
| rsp_valid | output | 1 | Registered outcome is valid |
| rsp_write | output | 1 | Direction of the resolved access |
| rsp_trap_l1 | output | 1 | Outcome: trap to level 1 |
| rsp_trap_l2 | output | 1 | Outcome: trap to level 2 |
| rsp_undef | output | 1 | Outcome: undefined instruction |
| rsp_redirect | output | 1 | Outcome: access goes to `rsp_target` |
| rsp_target | output | 2 | Redirect target code (see R3) |
| rsp_syndrome | output | 6 | Syndrome class of a trap |
| rsp_slot_offset | output | 12 | Memory slot offset for target 3 |

## Verification
Several rules can be true in the same request, and only the first one in priority order may win. Two cases matter most. At level 0 the kernel access trap and the level-2 counter trap can both hold. At level 1 the nested-virtualisation slot redirect and the counter trap can both hold. The bench provokes each case by clearing both enable bits, or by setting 0b111 together with a cleared counter enable, in one request. It judges the outcome by expecting only the higher-priority result on the one-hot outcome ports, with matching syndrome, target and slot offset.

// File: rtl/trr_pkg.sv
package trr_pkg;

    typedef enum logic [1:0] {
        ACT_TRAP_L1  = 2'd0,
        ACT_TRAP_L2  = 2'd1,
        ACT_UNDEF    = 2'd2,
        ACT_REDIRECT = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        DST_PLAIN   = 2'd0,
        DST_HYP     = 2'd1,
        DST_SEC_HYP = 2'd2,
        DST_SLOT    = 2'd3
    } dst_e;

    typedef struct packed {
        act_e act;
        dst_e dst;
    } route_t;

    typedef struct packed {
        logic   valid;
        logic   write;
        route_t route;
    } rsp_t;

    localparam logic [1:0] LVL0 = 2'd0;
    localparam logic [1:0] LVL1 = 2'd1;
    localparam logic [1:0] LVL2 = 2'd2;
    localparam logic [1:0] LVL3 = 2'd3;

    localparam logic [2:0] NV_SLOT_ALL   = 3'b111;
    localparam logic [2:0] NV_SLOT_ALIAS = 3'b101;

    // Host-mode redirect choice shared by the level-0 and level-2 paths.
    function automatic route_t host_redirect(input logic host, input logic ns,
                                             input logic sec_impl);
        route_t r;
        r.act = ACT_REDIRECT;
        if (host && !ns && sec_impl)
            r.dst = DST_SEC_HYP;
        else if (host && ns)
            r.dst = DST_HYP;
        else
            r.dst = DST_PLAIN;
        return r;
    endfunction

endpackage

// File: rtl/trr_enc_match.sv
module trr_enc_match #(
    parameter int         OP0_W     = 2,
    parameter int         OP1_W     = 3,
    parameter int         CR_W      = 4,
    parameter int         OP2_W     = 3,
    parameter logic [1:0] OP0_VAL   = 2'b11,
    parameter logic [2:0] OP1_DIR   = 3'b011,
    parameter logic [2:0] OP1_ALIAS = 3'b101,
    parameter logic [3:0] CRN_VAL   = 4'b1110,
    parameter logic [3:0] CRM_VAL   = 4'b0010,
    parameter logic [2:0] OP2_VAL   = 3'b001
) (
    input  logic [OP0_W-1:0] op0_i,
    input  logic [OP1_W-1:0] op1_i,
    input  logic [CR_W-1:0]  crn_i,
    input  logic [CR_W-1:0]  crm_i,
    input  logic [OP2_W-1:0] op2_i,
    output logic             hit_dir_o,
    output logic             hit_alias_o
);

    logic common_hit;

    always_comb begin
        common_hit  = (op0_i == OP0_VAL) && (crn_i == CRN_VAL) &&
                      (crm_i == CRM_VAL) && (op2_i == OP2_VAL);
        hit_dir_o   = common_hit && (op1_i == OP1_DIR);
        hit_alias_o = common_hit && (op1_i == OP1_ALIAS);
    end

endmodule

// File: rtl/trr_route_direct.sv
module trr_route_direct
    import trr_pkg::*;
(
    input  logic [1:0] level_i,
    input  logic       l2_en_i,
    input  logic       host_l2_i,
    input  logic       host_l0_i,
    input  logic       trap_gen_i,
    input  logic [2:0] nv_i,
    input  logic       ns_i,
    input  logic       sec_impl_i,
    input  logic       k_l0_tmr_en_i,
    input  logic       h_l1_cnt_en_i,
    input  logic       h_l1_tmr_en_i,
    input  logic       h_l0_tmr_en_i,
    output route_t     route_o
);

    always_comb begin
        route_o.act = ACT_REDIRECT;
        route_o.dst = DST_PLAIN;
        case (level_i)
            LVL0: begin
                if (!host_l0_i && !k_l0_tmr_en_i)
                    route_o.act = (l2_en_i && trap_gen_i) ? ACT_TRAP_L2 : ACT_TRAP_L1;
                else if (l2_en_i && !host_l2_i && !h_l1_cnt_en_i)
                    route_o.act = ACT_TRAP_L2;
                else if (host_l2_i && !trap_gen_i && !h_l1_tmr_en_i)
                    route_o.act = ACT_TRAP_L2;
                else if (host_l0_i && !h_l0_tmr_en_i)
                    route_o.act = ACT_TRAP_L2;
                else
                    route_o = host_redirect(host_l0_i, ns_i, sec_impl_i);
            end
            LVL1: begin
                if (l2_en_i && !host_l2_i && !h_l1_cnt_en_i)
                    route_o.act = ACT_TRAP_L2;
                else if (host_l2_i && !h_l1_tmr_en_i)
                    route_o.act = ACT_TRAP_L2;
                else if (nv_i == NV_SLOT_ALL)
                    route_o.dst = DST_SLOT;
            end
            LVL2: route_o = host_redirect(host_l2_i, ns_i, sec_impl_i);
            default: begin
                route_o.act = ACT_REDIRECT;
                route_o.dst = DST_PLAIN;
            end
        endcase
    end

endmodule

// File: rtl/trr_route_alias.sv
module trr_route_alias
    import trr_pkg::*;
(
    input  logic [1:0] level_i,
    input  logic       l2_en_i,
    input  logic       host_l2_i,
    input  logic       host_l0_i,
    input  logic [2:0] nv_i,
    input  logic       h_l1_nv_trap_i,
    output route_t     route_o
);

    always_comb begin
        route_o.act = ACT_UNDEF;
        route_o.dst = DST_PLAIN;
        case (level_i)
            LVL0: route_o.act = ACT_UNDEF;
            LVL1: begin
                if (nv_i == NV_SLOT_ALIAS) begin
                    if (l2_en_i && !host_l0_i && h_l1_nv_trap_i) begin
                        route_o.act = ACT_TRAP_L2;
                    end else begin
                        route_o.act = ACT_REDIRECT;
                        route_o.dst = DST_SLOT;
                    end
                end else if (nv_i[0]) begin
                    route_o.act = ACT_TRAP_L2;
                end else begin
                    route_o.act = ACT_UNDEF;
                end
            end
            default: begin
                if (host_l2_i)
                    route_o.act = ACT_REDIRECT;
                else
                    route_o.act = ACT_UNDEF;
            end
        endcase
    end

endmodule

// File: rtl/timer_ctl_access_router.sv
module timer_ctl_access_router
    import trr_pkg::*;
#(
    parameter int                SYND_W      = 6,
    parameter logic [SYND_W-1:0] SYND_CLASS  = 6'h18,
    parameter int                OFF_W       = 12,
    parameter logic [OFF_W-1:0]  SLOT_OFFSET = 12'h180,
    parameter logic [1:0]        OP0_VAL     = 2'b11,
    parameter logic [2:0]        OP1_DIR     = 3'b011,
    parameter logic [2:0]        OP1_ALIAS   = 3'b101,
    parameter logic [3:0]        CRN_VAL     = 4'b1110,
    parameter logic [3:0]        CRM_VAL     = 4'b0010,
    parameter logic [2:0]        OP2_VAL     = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_level,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              l2_enabled,
    input  logic              host_l2,
    input  logic              host_l0,
    input  logic              trap_general,
    input  logic [2:0]        nv_bits,
    input  logic              nonsecure,
    input  logic              sec_l2_impl,
    input  logic              kctl_l0_timer_en,
    input  logic              hctl_l1_cnt_en,
    input  logic              hctl_l1_timer_en,
    input  logic              hctl_l0_timer_en,
    input  logic              hctl_l1_nv_trap,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic              rsp_trap_l1,
    output logic              rsp_trap_l2,
    output logic              rsp_undef,
    output logic              rsp_redirect,
    output logic [1:0]        rsp_target,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic [OFF_W-1:0]  rsp_slot_offset
);

    localparam logic [SYND_W-1:0] SYND_NONE = '0;
    localparam logic [OFF_W-1:0]  OFF_NONE  = '0;

    logic   hit_dir, hit_alias;
    route_t route_dir, route_alias;
    rsp_t   rsp_d, rsp_q;

    trr_enc_match #(
        .OP0_VAL(OP0_VAL), .OP1_DIR(OP1_DIR), .OP1_ALIAS(OP1_ALIAS),
        .CRN_VAL(CRN_VAL), .CRM_VAL(CRM_VAL), .OP2_VAL(OP2_VAL)
    ) u_match (
        .op0_i(req_op0), .op1_i(req_op1), .crn_i(req_crn),
        .crm_i(req_crm), .op2_i(req_op2),
        .hit_dir_o(hit_dir), .hit_alias_o(hit_alias)
    );

    trr_route_direct u_direct (
        .level_i(req_level), .l2_en_i(l2_enabled), .host_l2_i(host_l2),
        .host_l0_i(host_l0), .trap_gen_i(trap_general), .nv_i(nv_bits),
        .ns_i(nonsecure), .sec_impl_i(sec_l2_impl),
        .k_l0_tmr_en_i(kctl_l0_timer_en), .h_l1_cnt_en_i(hctl_l1_cnt_en),
        .h_l1_tmr_en_i(hctl_l1_timer_en), .h_l0_tmr_en_i(hctl_l0_timer_en),
        .route_o(route_dir)
    );

    trr_route_alias u_alias (
        .level_i(req_level), .l2_en_i(l2_enabled), .host_l2_i(host_l2),
        .host_l0_i(host_l0), .nv_i(nv_bits), .h_l1_nv_trap_i(hctl_l1_nv_trap),
        .route_o(route_alias)
    );

    always_comb begin
        rsp_d.valid     = req_valid && (hit_dir || hit_alias);
        rsp_d.write     = req_write;
        rsp_d.route     = hit_alias ? route_alias : route_dir;
        if (!rsp_d.valid) begin
            rsp_d.write     = 1'b0;
            rsp_d.route.act = ACT_TRAP_L1;
            rsp_d.route.dst = DST_PLAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q.valid     <= 1'b0;
            rsp_q.write     <= 1'b0;
            rsp_q.route.act <= ACT_TRAP_L1;
            rsp_q.route.dst <= DST_PLAIN;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        rsp_valid       = rsp_q.valid;
        rsp_write       = rsp_q.write;
        rsp_trap_l1     = rsp_q.valid && (rsp_q.route.act == ACT_TRAP_L1);
        rsp_trap_l2     = rsp_q.valid && (rsp_q.route.act == ACT_TRAP_L2);
        rsp_undef       = rsp_q.valid && (rsp_q.route.act == ACT_UNDEF);
        rsp_redirect    = rsp_q.valid && (rsp_q.route.act == ACT_REDIRECT);
        rsp_target      = rsp_redirect ? rsp_q.route.dst : DST_PLAIN;
        rsp_syndrome    = (rsp_trap_l1 || rsp_trap_l2) ? SYND_CLASS : SYND_NONE;
        rsp_slot_offset = (rsp_redirect && rsp_target == DST_SLOT) ? SLOT_OFFSET : OFF_NONE;
    end

    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_trap_l1, rsp_trap_l2, rsp_undef, rsp_redirect}) == 1); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_trap_l1 || rsp_trap_l2 || rsp_undef || rsp_redirect)); // R2

    AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap_l1 || rsp_trap_l2) |-> rsp_syndrome == SYND_CLASS); // R3

    AST_SLOT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_slot_offset != OFF_NONE) |-> (rsp_redirect && rsp_target == 2'd3)); // R3

    AST_L3_DIRECT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd3 && req_op0 == OP0_VAL && req_op1 == OP1_DIR &&
         req_crn == CRN_VAL && req_crm == CRM_VAL && req_op2 == OP2_VAL)
        |=> (rsp_redirect && rsp_target == 2'd0)); // R8

    AST_L0_ALIAS_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd0 && req_op0 == OP0_VAL && req_op1 == OP1_ALIAS &&
         req_crn == CRN_VAL && req_crm == CRM_VAL && req_op2 == OP2_VAL)
        |=> rsp_undef); // R9

endmodule

// File: tb/timer_ctl_access_router_tb.sv
module timer_ctl_access_router_tb;

    localparam int K_T1 = 0, K_T2 = 1, K_UD = 2, K_RD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_level = 2'd0, req_op0 = 2'b11;
    logic [2:0] req_op1 = 3'b011, req_op2 = 3'b001;
    logic [3:0] req_crn = 4'b1110, req_crm = 4'b0010;
    logic l2_enabled, host_l2, host_l0, trap_general, nonsecure, sec_l2_impl;
    logic [2:0] nv_bits;
    logic kctl_l0_timer_en, hctl_l1_cnt_en, hctl_l1_timer_en, hctl_l0_timer_en, hctl_l1_nv_trap;
    logic rsp_valid, rsp_write, rsp_trap_l1, rsp_trap_l2, rsp_undef, rsp_redirect;
    logic [1:0] rsp_target;
    logic [5:0] rsp_syndrome;
    logic [11:0] rsp_slot_offset;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    timer_ctl_access_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_level(req_level), .req_op0(req_op0), .req_op1(req_op1),
        .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .l2_enabled(l2_enabled), .host_l2(host_l2), .host_l0(host_l0),
        .trap_general(trap_general), .nv_bits(nv_bits), .nonsecure(nonsecure),
        .sec_l2_impl(sec_l2_impl), .kctl_l0_timer_en(kctl_l0_timer_en),
        .hctl_l1_cnt_en(hctl_l1_cnt_en), .hctl_l1_timer_en(hctl_l1_timer_en),
        .hctl_l0_timer_en(hctl_l0_timer_en), .hctl_l1_nv_trap(hctl_l1_nv_trap),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_trap_l1(rsp_trap_l1),
        .rsp_trap_l2(rsp_trap_l2), .rsp_undef(rsp_undef), .rsp_redirect(rsp_redirect),
        .rsp_target(rsp_target), .rsp_syndrome(rsp_syndrome),
        .rsp_slot_offset(rsp_slot_offset)
    );

    task automatic ctl_default();
        l2_enabled = 1'b1; host_l2 = 1'b0; host_l0 = 1'b0; trap_general = 1'b0;
        nv_bits = 3'b000; nonsecure = 1'b1; sec_l2_impl = 1'b0;
        kctl_l0_timer_en = 1'b1; hctl_l1_cnt_en = 1'b1; hctl_l1_timer_en = 1'b1;
        hctl_l0_timer_en = 1'b1; hctl_l1_nv_trap = 1'b0;
    endtask

    // Drive one request at a falling edge; the registered response is
    // present at the next falling edge, where it is checked.
    task automatic send(input logic [1:0] lvl, input logic alias_form, input logic wr,
                        input logic [3:0] crm = 4'b0010);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_level = lvl;
        req_op0 = 2'b11; req_op1 = alias_form ? 3'b101 : 3'b011;
        req_crn = 4'b1110; req_crm = crm; req_op2 = 3'b001;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input int kind, input int tgt,
                              input logic wr = 1'b0);
        logic [3:0] got_v, exp_v;
        logic [1:0] exp_t;
        logic [5:0] exp_s;
        logic [11:0] exp_o;
        got_v = {rsp_trap_l1, rsp_trap_l2, rsp_undef, rsp_redirect};
        exp_v = 4'b1000 >> kind;
        exp_t = (kind == K_RD) ? 2'(tgt) : 2'd0;
        exp_s = (kind == K_T1 || kind == K_T2) ? 6'h18 : 6'h00;
        exp_o = (kind == K_RD && tgt == 3) ? 12'h180 : 12'h000;
        n_checks++;
        if (rsp_valid !== 1'b1 || got_v !== exp_v || rsp_target !== exp_t ||
            rsp_syndrome !== exp_s || rsp_slot_offset !== exp_o || rsp_write !== wr) begin
            n_fail++;
            $display("FAIL %s: got v=%b out=%b tgt=%0d syn=%h off=%h wr=%b exp v=1 out=%b tgt=%0d syn=%h off=%h wr=%b",
                     tag, rsp_valid, got_v, rsp_target, rsp_syndrome, rsp_slot_offset, rsp_write,
                     exp_v, exp_t, exp_s, exp_o, wr);
        end
    endtask

    task automatic expect_none(input string tag);
        n_checks++;
        if (rsp_valid !== 1'b0 ||
            {rsp_trap_l1, rsp_trap_l2, rsp_undef, rsp_redirect} !== 4'b0000 ||
            rsp_syndrome !== 6'h00 || rsp_slot_offset !== 12'h000) begin
            n_fail++;
            $display("FAIL %s: got v=%b out=%b syn=%h off=%h exp v=0 out=0000 syn=00 off=000",
                     tag, rsp_valid, {rsp_trap_l1, rsp_trap_l2, rsp_undef, rsp_redirect},
                     rsp_syndrome, rsp_slot_offset);
        end
    endtask

    task automatic t_reset();
        expect_none("R2 reset state");
    endtask

    task automatic t_encoding();
        ctl_default();
        send(2'd3, 1'b0, 1'b0, 4'b0011);
        expect_none("R1 wrong CRm");
        send(2'd3, 1'b0, 1'b0);
        expect_rsp("R1 direct form matches", K_RD, 0);
        @(negedge clk);
        expect_none("R1 no request");
    endtask

    task automatic t_l0_kernel();
        ctl_default(); kctl_l0_timer_en = 1'b0; trap_general = 1'b1;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R4 kernel trap to l2", K_T2, 0);
        trap_general = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R4 kernel trap to l1 (R3 syndrome)", K_T1, 0);
        l2_enabled = 1'b0; trap_general = 1'b1;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R4 l2 disabled traps to l1", K_T1, 0);
    endtask

    task automatic t_l0_lower();
        ctl_default(); hctl_l1_cnt_en = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R5 counter trap", K_T2, 0);
        kctl_l0_timer_en = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R5 priority kernel trap beats counter trap", K_T1, 0);
        ctl_default(); host_l2 = 1'b1; host_l0 = 1'b1; hctl_l1_timer_en = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R5 host timer trap", K_T2, 0);
        ctl_default(); host_l2 = 1'b1; host_l0 = 1'b1; trap_general = 1'b1;
        kctl_l0_timer_en = 1'b0; hctl_l0_timer_en = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R5 host l0 timer trap", K_T2, 0);
    endtask

    task automatic t_host_redirect();
        ctl_default(); host_l2 = 1'b1; host_l0 = 1'b1; trap_general = 1'b1;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R6 l0 host nonsecure", K_RD, 1);
        nonsecure = 1'b0; sec_l2_impl = 1'b1;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R6 l0 host secure", K_RD, 2);
        sec_l2_impl = 1'b0;
        send(2'd0, 1'b0, 1'b0);
        expect_rsp("R6 l0 host secure unimplemented", K_RD, 0);
        ctl_default(); host_l2 = 1'b1;
        send(2'd2, 1'b0, 1'b0);
        expect_rsp("R6 l2 host nonsecure", K_RD, 1);
        nonsecure = 1'b0; sec_l2_impl = 1'b1;
        send(2'd2, 1'b0, 1'b0);
        expect_rsp("R6 l2 host secure", K_RD, 2);
        host_l2 = 1'b0;
        send(2'd2, 1'b0, 1'b0);
        expect_rsp("R6 l2 not host", K_RD, 0);
    endtask

    task automatic t_l1();
        ctl_default(); hctl_l1_cnt_en = 1'b0;
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R7 counter trap", K_T2, 0);
        nv_bits = 3'b111;
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R7 priority counter trap beats slot", K_T2, 0);
        ctl_default(); host_l2 = 1'b1; hctl_l1_timer_en = 1'b0;
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R7 host timer trap", K_T2, 0);
        ctl_default(); nv_bits = 3'b111;
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R7 slot redirect (R3 offset)", K_RD, 3);
        nv_bits = 3'b101;
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R7 other nv plain", K_RD, 0);
    endtask

    task automatic t_l3();
        ctl_default(); host_l2 = 1'b1; hctl_l1_cnt_en = 1'b0; hctl_l1_timer_en = 1'b0;
        nv_bits = 3'b111; kctl_l0_timer_en = 1'b0;
        send(2'd3, 1'b0, 1'b0);
        expect_rsp("R8 l3 plain despite controls", K_RD, 0);
    endtask

    task automatic t_alias_outer();
        ctl_default(); host_l2 = 1'b1;
        send(2'd0, 1'b1, 1'b0);
        expect_rsp("R9 alias l0 undefined", K_UD, 0);
        send(2'd2, 1'b1, 1'b0);
        expect_rsp("R9 alias l2 host plain", K_RD, 0);
        send(2'd3, 1'b1, 1'b0);
        expect_rsp("R9 alias l3 host plain", K_RD, 0);
        host_l2 = 1'b0;
        send(2'd2, 1'b1, 1'b0);
        expect_rsp("R9 alias l2 not host", K_UD, 0);
        send(2'd3, 1'b1, 1'b0);
        expect_rsp("R9 alias l3 not host", K_UD, 0);
    endtask

    task automatic t_alias_l1();
        ctl_default(); nv_bits = 3'b101;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv101 slot", K_RD, 3);
        hctl_l1_nv_trap = 1'b1;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv101 trap bit", K_T2, 0);
        host_l0 = 1'b1;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv101 trap bit host l0", K_RD, 3);
        ctl_default(); nv_bits = 3'b111;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv111", K_T2, 0);
        nv_bits = 3'b001;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv001", K_T2, 0);
        nv_bits = 3'b100;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv100", K_UD, 0);
        nv_bits = 3'b000;
        send(2'd1, 1'b1, 1'b0);
        expect_rsp("R10 alias nv000", K_UD, 0);
    endtask

    task automatic t_direction();
        ctl_default(); nv_bits = 3'b111;
        send(2'd1, 1'b0, 1'b1);
        expect_rsp("R11 write slot", K_RD, 3, 1'b1);
        send(2'd1, 1'b0, 1'b0);
        expect_rsp("R11 read slot", K_RD, 3, 1'b0);
        kctl_l0_timer_en = 1'b0;
        send(2'd0, 1'b0, 1'b1);
        expect_rsp("R11 write trap", K_T1, 0, 1'b1);
    endtask

    initial begin
        ctl_default();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_encoding();
        t_l0_kernel();
        t_l0_lower();
        t_host_redirect();
        t_l1();
        t_l3();
        t_alias_outer();
        t_alias_l1();
        t_direction();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule